// File: doc/BRIEF.md
# PS/2 Host Port Controller

This block is the host end of a two-wire PS/2 link. The clock and data wires are open-drain. The block sees each wire as a sampled input, and it drives each wire through a "pull low" enable. A pull-up outside the block is assumed. Software works the port through a small set of register-style strobes and levels: a port enable, a direction bit, a transmit-byte write, a receive-byte read, and status levels for received-data-ready, transmitter-idle, parity error, timeout and missing acknowledge.

In receive mode the device drives the clock, and the host collects 11-bit frames. After a good frame the host pulls the clock low, which stops the device from sending anything more. It keeps the clock low until software reads the byte. In transmit mode, software first sets the direction bit. The host then pulls the clock low to inhibit the device. A write to the transmit buffer starts the request-to-send sequence: data goes low, and a few cycles later the clock is released. The device then clocks the frame out of the host.

Both wires pass through a synchronizer and a glitch filter before any edge is detected. A watchdog ends any frame in which the clock stops toggling.

Top module: `ps2_host_port`

## Requirements
- R1: A receive frame is a start bit of 0, then eight data bits with bit 0 first, then a parity bit and a stop bit. Each bit is sampled on a falling edge of the filtered clock. A start edge that finds data high is ignored. After the 11th falling edge, if parity is good, the byte appears on `rx_rdata` and `rx_ready` goes to 1.
- R2: Parity is odd: the eight data bits and the parity bit together hold an odd number of ones. A frame that breaks this rule sets `parity_err` and leaves `rx_ready` at 0. `parity_err` clears when the next start bit is accepted.
- R3: While the port is enabled, the direction is receive and `rx_ready` is 1, the host pulls the clock low and releases data. While `rx_ready` is 0 and the port is idle in receive mode, both lines are released.
- R4: A pulse on `rx_rd` while `rx_ready` is 1 has three results on the next cycle: `rx_ready` is 0, the clock is released, and `rx_rdata` reads 0xFF.
- R5: Suppose `cfg_enable` drops during a receive frame. If fewer than 10 falling edges have arrived, the byte is discarded and `rx_ready` stays 0. If the 10th edge (the parity bit) has arrived, the byte is stored and `rx_ready` is set, provided parity is good.
- R6: While the direction bit is 1 and no transfer is running, the host pulls the clock low and releases data. It holds this state until the transmit buffer is written or the direction bit is cleared. Clearing the direction bit releases the clock.
- R7: A transmit write is ignored in each of these cases:
  - `cfg_enable` is 0;
  - the direction bit is 0;
  - a transmission is running (`tx_idle` is 0);
  - `rx_ready` is 1.
- R8: An accepted transmit write drives `tx_idle` to 0 and pulls data low while the clock stays low. The clock is released RTS_DELAY cycles after the write is accepted, with data still low.
- R9: On falling edges 1 to 10 of the device clock, the host drives in turn data bits 0 to 7, the odd parity bit and a stop bit of 1 (data released). The device samples each of these on the following rising edge.
- R10: On the 11th falling edge, the transmission ends: the direction bit returns to 0 and `tx_idle` returns to 1. If data is high at that edge (no acknowledge), `tx_nack` is set; it clears at the next transmit start.
- R11: If no falling clock edge arrives for TO_CYCLES cycles during a receive or transmit frame, the frame is aborted. `timeout_err` is set, `rx_rdata` is reloaded with 0xFF, and the direction bit is cleared if a transmission was running. `timeout_err` clears at the next frame start.
- R12: While `cfg_enable` is 0, both lines are released.
- R13: A pulse on a line shorter than FILT_LEN cycles, after the synchronizer, does not reach edge detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Port enable level |
| dir_wr | input | 1 | Direction bit write strobe |
| dir_wdata | input | 1 | Direction value, 1 = transmit |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_wdata | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Receive buffer read strobe |
| rx_rdata | output | 8 | Receive buffer, 0xFF when empty |
| dir_tx | output | 1 | Current direction bit |
| rx_ready | output | 1 | Received byte waiting |
| tx_idle | output | 1 | No transmission running |
| parity_err | output | 1 | Last received frame failed odd parity |
| timeout_err | output | 1 | Last frame was aborted by the watchdog |
| tx_nack | output | 1 | Last transmission saw no acknowledge |
| ps2_clk_in | input | 1 | Sampled clock wire |
| ps2_dat_in | input | 1 | Sampled data wire |
| ps2_clk_low | output | 1 | Pull clock wire low |
| ps2_dat_low | output | 1 | Pull data wire low |

## Verification
The bench builds the port with FILT_LEN = 3, TO_CYCLES = 300 and RTS_DELAY = 4. The device model runs a bit period of 40 system cycles. With a 300-cycle watchdog, a stalled frame can be aborted and checked in a few hundred cycles, while normal frames never come near the limit. The short filter allows a 2-cycle glitch that must be rejected. The 4-cycle request-to-send delay lets the bench count each cycle of the handover between clock and data.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ARM,
        ST_RTS,
        ST_TX
    } ps2h_state_e;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned LINES     = 2;
    localparam int unsigned IDX_CLK   = 0;
    localparam int unsigned IDX_DAT   = 1;
    localparam logic [3:0]  LAST_EDGE = 4'd10;
    localparam logic [BYTE_W-1:0] RX_EMPTY = 8'hFF;

    typedef struct packed {
        logic              stop;
        logic              par;
        logic [BYTE_W-1:0] data;
    } ps2h_txfrm_t;

    function automatic logic odd_bit(input logic [BYTE_W-1:0] d);
        return ~^d;
    endfunction

    function automatic logic frame_ok(input logic [BYTE_W-1:0] d, input logic p);
        return ^{d, p};
    endfunction

endpackage

// File: rtl/ps2h_line_filter.sv
module ps2h_line_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   settled;

    assign settled = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            run_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            if (settled != line_o) begin
                if (run_q == CW'(FILT_LEN - 1)) begin
                    line_o <= settled;
                    run_q  <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    // R13: the output only moves toward a level the synchronizer has held
    p_filter_follows_r13: assert property (@(posedge clk) disable iff (rst)
        (line_o != $past(line_o)) |-> ($past(settled) == line_o));

endmodule

// File: rtl/ps2h_watchdog.sv
module ps2h_watchdog #(
    parameter int unsigned TO_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic kick,
    output logic expire
);
    localparam int unsigned CW = $clog2(TO_CYCLES + 1);

    logic [CW-1:0] quiet_q;

    assign expire = active && !kick && (quiet_q == CW'(TO_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || !active || kick) begin
            quiet_q <= '0;
        end else if (!expire) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    // R11: expiry only after a stretch of active, edge-free cycles
    p_expire_after_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        expire |-> ($past(active) && !$past(kick)));

endmodule

// File: rtl/ps2h_engine.sv
module ps2h_engine
    import ps2h_pkg::*;
#(
    parameter int unsigned RTS_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              dir_wr,
    input  logic              dir_wdata,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_wdata,
    input  logic              rx_rd,
    input  logic              clk_f,
    input  logic              dat_f,
    input  logic              wd_expire,
    output logic              wd_active,
    output logic              wd_kick,
    output logic              clk_low_o,
    output logic              dat_low_o,
    output logic [BYTE_W-1:0] rx_rdata,
    output logic              dir_tx,
    output logic              rx_ready,
    output logic              tx_idle,
    output logic              parity_err,
    output logic              timeout_err,
    output logic              tx_nack
);
    localparam int unsigned RW = $clog2(RTS_DELAY + 1);

    ps2h_state_e       state_q;
    logic [3:0]        edge_q;
    logic [BYTE_W-1:0] rx_sh_q;
    logic              rx_par_q;
    logic [9:0]        tx_sh_q;
    logic              dat_drv_q;
    logic [RW-1:0]     rts_q;
    logic              clk_f_q;

    logic              fall;
    logic              tx_accept;
    logic              rx_done;
    logic              rx_good;
    ps2h_txfrm_t       tx_frame;

    assign fall      = clk_f_q && !clk_f;
    assign tx_accept = en && dir_tx && (state_q == ST_ARM) && !rx_ready && tx_wr;
    assign rx_done   = (state_q == ST_RX) &&
                       ((en && !wd_expire && fall && edge_q == LAST_EDGE) ||
                        (!en && edge_q >= LAST_EDGE));
    assign rx_good   = frame_ok(rx_sh_q, rx_par_q);
    assign tx_frame  = '{stop: 1'b1, par: odd_bit(tx_wdata), data: tx_wdata};

    assign tx_idle   = !((state_q == ST_RTS) || (state_q == ST_TX));
    assign wd_active = en && ((state_q == ST_RX) || (state_q == ST_TX));
    assign wd_kick   = fall;
    assign clk_low_o = en && (((state_q == ST_IDLE) && rx_ready) ||
                              (state_q == ST_ARM) || (state_q == ST_RTS));
    assign dat_low_o = en && dat_drv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            edge_q      <= '0;
            rx_sh_q     <= '0;
            rx_par_q    <= 1'b0;
            tx_sh_q     <= '0;
            dat_drv_q   <= 1'b0;
            rts_q       <= '0;
            clk_f_q     <= 1'b1;
            rx_rdata    <= RX_EMPTY;
            rx_ready    <= 1'b0;
            dir_tx      <= 1'b0;
            parity_err  <= 1'b0;
            timeout_err <= 1'b0;
            tx_nack     <= 1'b0;
        end else begin
            clk_f_q <= clk_f;

            if (rx_rd) begin
                rx_ready <= 1'b0;
                rx_rdata <= RX_EMPTY;
            end

            if (dir_wr && tx_idle) begin
                dir_tx <= dir_wdata;
            end

            if (rx_done) begin
                if (rx_good) begin
                    rx_rdata <= rx_sh_q;
                    rx_ready <= 1'b1;
                end else begin
                    parity_err <= 1'b1;
                end
            end

            if (!en) begin
                state_q   <= ST_IDLE;
                dat_drv_q <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (dir_tx) begin
                            state_q <= ST_ARM;
                        end else if (!rx_ready && fall && !dat_f) begin
                            state_q     <= ST_RX;
                            edge_q      <= 4'd1;
                            parity_err  <= 1'b0;
                            timeout_err <= 1'b0;
                        end
                    end
                    ST_RX: begin
                        if (wd_expire) begin
                            timeout_err <= 1'b1;
                            rx_rdata    <= RX_EMPTY;
                            state_q     <= ST_IDLE;
                        end else if (fall) begin
                            if (edge_q <= 4'd8) begin
                                rx_sh_q <= {dat_f, rx_sh_q[BYTE_W-1:1]};
                            end else if (edge_q == 4'd9) begin
                                rx_par_q <= dat_f;
                            end
                            if (edge_q == LAST_EDGE) begin
                                state_q <= ST_IDLE;
                            end
                            edge_q <= edge_q + 4'd1;
                        end
                    end
                    ST_ARM: begin
                        if (!dir_tx) begin
                            state_q <= ST_IDLE;
                        end else if (tx_accept) begin
                            tx_sh_q     <= tx_frame;
                            dat_drv_q   <= 1'b1;
                            rts_q       <= '0;
                            timeout_err <= 1'b0;
                            tx_nack     <= 1'b0;
                            state_q     <= ST_RTS;
                        end
                    end
                    ST_RTS: begin
                        rts_q <= rts_q + 1'b1;
                        if (rts_q == RW'(RTS_DELAY - 1)) begin
                            edge_q  <= '0;
                            state_q <= ST_TX;
                        end
                    end
                    ST_TX: begin
                        if (wd_expire) begin
                            timeout_err <= 1'b1;
                            rx_rdata    <= RX_EMPTY;
                            dir_tx      <= 1'b0;
                            dat_drv_q   <= 1'b0;
                            state_q     <= ST_IDLE;
                        end else if (fall) begin
                            if (edge_q == LAST_EDGE) begin
                                tx_nack   <= dat_f;
                                dir_tx    <= 1'b0;
                                dat_drv_q <= 1'b0;
                                state_q   <= ST_IDLE;
                            end else begin
                                dat_drv_q <= !tx_sh_q[0];
                                tx_sh_q   <= {1'b0, tx_sh_q[9:1]};
                                edge_q    <= edge_q + 4'd1;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R3: a waiting byte in receive mode keeps the device held off
    p_hold_while_ready_r3: assert property (@(posedge clk) disable iff (rst)
        (en && rx_ready && !dir_tx) |-> (clk_low_o && !dat_low_o));

    // R4: reading a waiting byte empties the buffer
    p_read_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && rx_ready) |=> (!rx_ready && rx_rdata == RX_EMPTY));

    // R7: no transmission starts while a received byte waits
    p_no_tx_over_rx_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_idle) |-> !$past(rx_ready));

    // R8: clock is handed back only with data already low
    p_rts_order_r8: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && $past(state_q) == ST_RTS && state_q == ST_TX)
            |-> (dat_low_o && !clk_low_o));

    // R10: end of transmission always returns direction to receive
    p_tx_end_dir_r10: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_idle) && en) |-> !dir_tx);

    // R12: a disabled port never pulls a wire
    p_disabled_release_r12: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!clk_low_o && !dat_low_o));

endmodule

// File: rtl/ps2_host_port.sv
module ps2_host_port
    import ps2h_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 4,
    parameter int unsigned TO_CYCLES   = 20000,
    parameter int unsigned RTS_DELAY   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_enable,
    input  logic       dir_wr,
    input  logic       dir_wdata,
    input  logic       tx_wr,
    input  logic [7:0] tx_wdata,
    input  logic       rx_rd,
    output logic [7:0] rx_rdata,
    output logic       dir_tx,
    output logic       rx_ready,
    output logic       tx_idle,
    output logic       parity_err,
    output logic       timeout_err,
    output logic       tx_nack,
    input  logic       ps2_clk_in,
    input  logic       ps2_dat_in,
    output logic       ps2_clk_low,
    output logic       ps2_dat_low
);
    logic [LINES-1:0] line_raw;
    logic [LINES-1:0] line_flt;
    logic             wd_active;
    logic             wd_kick;
    logic             wd_expire;

    assign line_raw[IDX_CLK] = ps2_clk_in;
    assign line_raw[IDX_DAT] = ps2_dat_in;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        ps2h_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst   (rst),
            .line_i(line_raw[i]),
            .line_o(line_flt[i])
        );
    end

    ps2h_watchdog #(
        .TO_CYCLES(TO_CYCLES)
    ) u_wd (
        .clk   (clk),
        .rst   (rst),
        .active(wd_active),
        .kick  (wd_kick),
        .expire(wd_expire)
    );

    ps2h_engine #(
        .RTS_DELAY(RTS_DELAY)
    ) u_eng (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_enable),
        .dir_wr     (dir_wr),
        .dir_wdata  (dir_wdata),
        .tx_wr      (tx_wr),
        .tx_wdata   (tx_wdata),
        .rx_rd      (rx_rd),
        .clk_f      (line_flt[IDX_CLK]),
        .dat_f      (line_flt[IDX_DAT]),
        .wd_expire  (wd_expire),
        .wd_active  (wd_active),
        .wd_kick    (wd_kick),
        .clk_low_o  (ps2_clk_low),
        .dat_low_o  (ps2_dat_low),
        .rx_rdata   (rx_rdata),
        .dir_tx     (dir_tx),
        .rx_ready   (rx_ready),
        .tx_idle    (tx_idle),
        .parity_err (parity_err),
        .timeout_err(timeout_err),
        .tx_nack    (tx_nack)
    );

endmodule

// File: tb/tb_ps2_host_port.sv
module tb_ps2_host_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 20;
    localparam int FILT       = 3;
    localparam int TO_CYC     = 300;
    localparam int RTS_D      = 4;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_enable = 1'b0;
    logic       dir_wr = 1'b0;
    logic       dir_wdata = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_wdata = 8'h00;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_rdata;
    logic       dir_tx, rx_ready, tx_idle, parity_err, timeout_err, tx_nack;
    logic       ps2_clk_low, ps2_dat_low;
    logic       dev_clk_low = 1'b0;
    logic       dev_dat_low = 1'b0;
    logic       clk_line, dat_line;

    assign clk_line = !(ps2_clk_low || dev_clk_low);
    assign dat_line = !(ps2_dat_low || dev_dat_low);

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ps2_host_port #(
        .SYNC_STAGES(2), .FILT_LEN(FILT), .TO_CYCLES(TO_CYC), .RTS_DELAY(RTS_D)
    ) dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable),
        .dir_wr(dir_wr), .dir_wdata(dir_wdata),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
        .rx_rdata(rx_rdata), .dir_tx(dir_tx), .rx_ready(rx_ready),
        .tx_idle(tx_idle), .parity_err(parity_err), .timeout_err(timeout_err),
        .tx_nack(tx_nack), .ps2_clk_in(clk_line), .ps2_dat_in(dat_line),
        .ps2_clk_low(ps2_clk_low), .ps2_dat_low(ps2_dat_low)
    );

    function automatic logic exp_par(input logic [7:0] b);
        return ~^b;
    endfunction

    function automatic logic [10:0] exp_frame(input logic [7:0] b, input bit bad);
        return {1'b1, exp_par(b) ^ bad, b, 1'b0};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_dir(input logic v);
        dir_wdata = v; dir_wr = 1'b1; tick(1); dir_wr = 1'b0;
    endtask

    task automatic write_tx(input logic [7:0] b);
        tx_wdata = b; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
    endtask

    task automatic read_rx();
        rx_rd = 1'b1; tick(1); rx_rd = 1'b0;
    endtask

    // device sends the first nclk bits of a frame
    task automatic dev_send(input logic [7:0] b, input bit bad, input int nclk);
        logic [10:0] f;
        f = exp_frame(b, bad);
        for (int i = 0; i < nclk; i++) begin
            dev_dat_low = !f[i];
            tick(HALF_BIT/2);
            dev_clk_low = 1'b1;
            tick(HALF_BIT);
            dev_clk_low = 1'b0;
            tick(HALF_BIT/2);
        end
        dev_dat_low = 1'b0;
    endtask

    // device clocks a host frame in, sampling on rising edges
    task automatic dev_recv(output logic [7:0] b, output logic p,
                            output logic stp, input bit give_ack);
        logic [10:1] f;
        int guard;
        f = '0;
        guard = 0;
        while (!(ps2_clk_low == 1'b0 && ps2_dat_low == 1'b1) && guard < 1000) begin
            tick(1); guard++;
        end
        tick(HALF_BIT/2);
        for (int k = 1; k <= 10; k++) begin
            dev_clk_low = 1'b1;
            tick(HALF_BIT);
            dev_clk_low = 1'b0;
            tick(1);
            f[k] = dat_line;
            tick(HALF_BIT - 1);
        end
        dev_dat_low = give_ack;
        tick(HALF_BIT/2);
        dev_clk_low = 1'b1;
        tick(HALF_BIT);
        dev_clk_low = 1'b0;
        tick(HALF_BIT/2);
        dev_dat_low = 1'b0;
        b = f[8:1]; p = f[9]; stp = f[10];
    endtask

    task automatic tx_round(input logic [7:0] b, input bit give_ack, input string tag);
        logic [7:0] got; logic gp, gs;
        set_dir(1'b1);
        tick(3);
        write_tx(b);
        dev_recv(got, gp, gs, give_ack);
        tick(10);
        chk("R9", {tag, " byte"}, got, b);
        chk("R9", {tag, " parity"}, gp, exp_par(b));
        chk("R9", {tag, " stop"}, gs, 1'b1);
        chk("R10", {tag, " dir cleared"}, dir_tx, 1'b0);
        chk("R10", {tag, " idle"}, tx_idle, 1'b1);
        chk("R10", {tag, " nack"}, tx_nack, !give_ack);
    endtask

    initial begin : wd
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] b, got; logic gp, gs;
        bit bad;
        void'($urandom(32'h0005_EED1));
        tick(5);
        rst = 1'b0;
        tick(2);
        // reset state
        chk("R4", "reset rdata", rx_rdata, 8'hFF);
        chk("R1", "reset ready", rx_ready, 1'b0);
        chk("R10", "reset idle", tx_idle, 1'b1);
        chk("R12", "reset clk", ps2_clk_low, 1'b0);
        chk("R12", "reset dat", ps2_dat_low, 1'b0);

        cfg_enable = 1'b1;
        tick(5);
        chk("R3", "idle clk released", ps2_clk_low, 1'b0);

        // R1 directed receive
        dev_send(8'hA5, 1'b0, 11);
        tick(5);
        chk("R1", "rx ready", rx_ready, 1'b1);
        chk("R1", "rx byte", rx_rdata, 8'hA5);
        chk("R2", "no parity err", parity_err, 1'b0);
        chk("R3", "clk held", ps2_clk_low, 1'b1);
        chk("R3", "dat released", ps2_dat_low, 1'b0);
        tick(30);
        chk("R3", "clk still held", ps2_clk_low, 1'b1);
        read_rx();
        chk("R4", "ready cleared", rx_ready, 1'b0);
        chk("R4", "rdata reload", rx_rdata, 8'hFF);
        chk("R4", "clk released", ps2_clk_low, 1'b0);
        tick(10);

        // R2 parity error
        dev_send(8'h3C, 1'b1, 11);
        tick(5);
        chk("R2", "bad parity ready", rx_ready, 1'b0);
        chk("R2", "bad parity flag", parity_err, 1'b1);
        tick(10);

        // R1/R2 random receive
        for (int i = 0; i < 10; i++) begin
            b = 8'($urandom_range(0, 255));
            bad = ($urandom_range(0, 3) == 0);
            dev_send(b, bad, 11);
            tick(5);
            chk("R2", "rand ready", rx_ready, !bad);
            chk("R2", "rand perr", parity_err, bad);
            if (!bad) begin
                chk("R1", "rand byte", rx_rdata, b);
                read_rx();
            end
            tick(10);
        end

        // R13 glitch on clock with data low
        dev_dat_low = 1'b1;
        dev_clk_low = 1'b1; tick(2); dev_clk_low = 1'b0;
        tick(4);
        dev_dat_low = 1'b0;
        tick(20);
        dev_send(8'h5A, 1'b0, 11);
        tick(5);
        chk("R13", "after glitch ready", rx_ready, 1'b1);
        chk("R13", "after glitch byte", rx_rdata, 8'h5A);
        read_rx();
        tick(10);

        // R5 enable dropped before the parity edge
        dev_send(8'h81, 1'b0, 9);
        tick(5);
        cfg_enable = 1'b0;
        tick(3);
        chk("R5", "early drop discarded", rx_ready, 1'b0);
        chk("R12", "disabled clk", ps2_clk_low, 1'b0);
        cfg_enable = 1'b1;
        tick(10);

        // R5 enable dropped after the parity edge
        dev_send(8'h42, 1'b0, 10);
        tick(5);
        cfg_enable = 1'b0;
        tick(3);
        chk("R5", "late drop kept", rx_ready, 1'b1);
        chk("R5", "late drop byte", rx_rdata, 8'h42);
        chk("R12", "disabled clk while ready", ps2_clk_low, 1'b0);
        chk("R12", "disabled dat", ps2_dat_low, 1'b0);
        cfg_enable = 1'b1;
        tick(2);
        chk("R3", "reenable holds clk", ps2_clk_low, 1'b1);
        read_rx();
        tick(10);

        // R11 receive timeout
        dev_send(8'h11, 1'b0, 5);
        tick(TO_CYC + 60);
        chk("R11", "rx timeout flag", timeout_err, 1'b1);
        chk("R11", "rx timeout ready", rx_ready, 1'b0);
        chk("R11", "rx timeout rdata", rx_rdata, 8'hFF);
        dev_send(8'h66, 1'b0, 11);
        tick(5);
        chk("R11", "flag cleared by new frame", timeout_err, 1'b0);
        chk("R1", "post timeout byte", rx_rdata, 8'h66);
        read_rx();
        tick(10);

        // R7 write with direction receive
        write_tx(8'h55);
        tick(2);
        chk("R7", "dir0 write idle", tx_idle, 1'b1);
        chk("R7", "dir0 write dat", ps2_dat_low, 1'b0);

        // R7 write while disabled
        cfg_enable = 1'b0;
        set_dir(1'b1);
        write_tx(8'h77);
        tick(2);
        chk("R7", "disabled write idle", tx_idle, 1'b1);
        chk("R12", "disabled armed clk", ps2_clk_low, 1'b0);
        cfg_enable = 1'b1;
        tick(3);
        chk("R6", "armed clk low", ps2_clk_low, 1'b1);
        chk("R6", "armed dat released", ps2_dat_low, 1'b0);
        tick(50);
        chk("R6", "armed hold", ps2_clk_low, 1'b1);
        set_dir(1'b0);
        tick(2);
        chk("R6", "disarm releases clk", ps2_clk_low, 1'b0);
        tick(10);

        // R7 receive byte waiting blocks transmit
        dev_send(8'h99, 1'b0, 11);
        tick(5);
        set_dir(1'b1);
        tick(2);
        write_tx(8'h12);
        tick(2);
        chk("R7", "ready blocks tx", tx_idle, 1'b1);
        chk("R7", "ready blocks dat", ps2_dat_low, 1'b0);
        chk("R1", "held byte intact", rx_rdata, 8'h99);
        read_rx();
        tick(2);
        chk("R6", "armed after read", ps2_clk_low, 1'b1);

        // R8 request-to-send timing, then R9/R10 transfer
        write_tx(8'hC3);
        chk("R8", "tx busy", tx_idle, 1'b0);
        chk("R8", "rts dat low", ps2_dat_low, 1'b1);
        chk("R8", "rts clk low", ps2_clk_low, 1'b1);
        tick(RTS_D - 1);
        chk("R8", "clk low until delay", ps2_clk_low, 1'b1);
        tick(1);
        chk("R8", "clk released", ps2_clk_low, 1'b0);
        chk("R8", "dat still low", ps2_dat_low, 1'b1);
        dev_recv(got, gp, gs, 1'b1);
        tick(10);
        chk("R9", "directed byte", got, 8'hC3);
        chk("R9", "directed parity", gp, exp_par(8'hC3));
        chk("R10", "directed dir", dir_tx, 1'b0);
        chk("R10", "directed idle", tx_idle, 1'b1);
        tick(10);

        // R7 write during an active transmission
        set_dir(1'b1);
        tick(3);
        write_tx(8'h3A);
        fork
            dev_recv(got, gp, gs, 1'b1);
            begin
                tick(150);
                write_tx(8'h00);
            end
        join
        tick(10);
        chk("R7", "mid-frame write ignored", got, 8'h3A);
        tick(10);

        // R9/R10 random transmit
        for (int i = 0; i < 6; i++) begin
            tx_round(8'($urandom_range(0, 255)), 1'b1, "rand tx");
            tick(10);
        end

        // R10 missing acknowledge
        tx_round(8'hE7, 1'b0, "nack tx");
        tick(10);

        // R11 transmit timeout: device never clocks
        set_dir(1'b1);
        tick(3);
        write_tx(8'h24);
        tick(RTS_D + TO_CYC + 60);
        chk("R11", "tx timeout flag", timeout_err, 1'b1);
        chk("R11", "tx timeout dir", dir_tx, 1'b0);
        chk("R11", "tx timeout idle", tx_idle, 1'b1);
        chk("R11", "tx timeout dat", ps2_dat_low, 1'b0);
        chk("R11", "tx timeout rdata", rx_rdata, 8'hFF);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule